// File: doc/BRIEF.md
# Multi-Link Packet Route Table

This block is the routing lookup of one node in a small coherent multiprocessor fabric. For every destination node it keeps a route entry holding three independent 4-bit masks, one for each packet class (request, response, broadcast). A packet's destination index and class select one mask. That mask names the outlets the packet leaves through: the local node and/or any of three outgoing links. A broadcast mask may select several outlets, in which case the packet is copied to each of them.

Software programs the entries through a 32-bit configuration port. Each write is a read-modify-write: it supplies a keep mask and a set value, and the result lands in the same cycle.

A global bypass input stands in for the routing-disable control. While it is asserted, the table is ignored and every packet goes to one outlet taken from a strapped 2-bit default-link input. Lookup results are registered, so a result appears exactly one cycle after its request.

Top module: `route_table_top`

## Requirements
- R1: After reset every one of the eight entries reads back as 0x00010101, which routes request, response and broadcast packets to the local node only.
- R2: A write to an entry index 0..7 stores ((old AND cfg_keep) OR cfg_set) limited to the route fields (bits 3:0 request, 11:8 response, 19:16 broadcast). All other bits read zero. A write to an index of 8 or above changes no entry.
- R3: cfg_rdata shows the entry selected by cfg_idx in the same cycle, and shows zero for an index of 8 or above.
- R4: When bypass is low and the destination is 0..7, class 0 (request) returns bits 3:0 of that entry, class 1 (response) returns bits 11:8 and class 2 (broadcast) returns bits 19:16. In every mask, bit 0 is the local node, bit 1 is link 0, bit 2 is link 1 and bit 3 is link 2.
- R5: A broadcast mask with several bits set is returned unchanged, with every selected bit kept.
- R6: rte_valid follows lkp_valid by exactly one clock. In a cycle after lkp_valid was low, rte_mask and rte_unroutable are zero.
- R7: When bypass is low and either the destination is 8 or above or the class is 3, the result has a zero mask and rte_unroutable set.
- R8: When bypass is high, the result is one-hot no matter the destination, class or table contents. Strap 00 gives bit 1, 01 gives bit 2, 10 gives bit 3 and 11 gives bit 0. rte_unroutable stays low.
- R9: A lookup issued in the same cycle as a write to its entry returns the entry's value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the entry at cfg_idx |
| cfg_idx | input | 4 | Entry index for write and readback |
| cfg_keep | input | 32 | Bits of the old entry to keep |
| cfg_set | input | 32 | Bits ORed into the kept value |
| cfg_rdata | output | 32 | Current contents of the entry at cfg_idx |
| route_bypass | input | 1 | Ignore table, route via strapped default link |
| strap_dflt_link | input | 2 | Default outlet: 00 link0, 01 link1, 10 link2, 11 local |
| lkp_valid | input | 1 | Lookup request strobe |
| lkp_dest | input | 4 | Destination node index |
| lkp_class | input | 2 | 0 request, 1 response, 2 broadcast, 3 reserved |
| rte_valid | output | 1 | Route result valid |
| rte_mask | output | 4 | Outlet mask: bit0 local, bit1..3 links 0..2 |
| rte_unroutable | output | 1 | Destination or class not routable |

## Verification
A corrupted entry appears on cfg_rdata as soon as its index is selected, with no clock edge needed. It also appears on rte_mask one clock after any lookup of that entry in the affected class. A fault in the write-merge logic therefore shows up on the readback taken right after the write. A fault in class or outlet selection, the range check or the bypass decode shows up in the very next result cycle. Random mixes of writes, lookups and bypass periods compared against a bench model bring out stale or mis-merged entries within a few cycles of their creation.

// File: rtl/route_tbl_pkg.sv
package route_tbl_pkg;
  typedef enum logic [1:0] {
    CLS_REQ   = 2'b00,
    CLS_RSP   = 2'b01,
    CLS_BCAST = 2'b10,
    CLS_RSVD  = 2'b11
  } pkt_class_e;

  localparam int MASK_W       = 4;
  localparam int FIELD_STRIDE = 8;
  localparam int NUM_CLASSES  = 3;

  // Word with every route field fully set, stride 8 bits.
  function automatic logic [31:0] field_mask();
    logic [31:0] m;
    m = '0;
    for (int k = 0; k < NUM_CLASSES; k++) m[k*FIELD_STRIDE +: MASK_W] = '1;
    return m;
  endfunction

  // Word routing every class to the local node only.
  function automatic logic [31:0] local_only_word();
    logic [31:0] m;
    m = '0;
    for (int k = 0; k < NUM_CLASSES; k++) m[k*FIELD_STRIDE] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/route_entry_bank.sv
module route_entry_bank #(
  parameter int NUM_NODES = 8,
  parameter int IDX_W     = 4,
  parameter int DATA_W    = 32,
  parameter logic [DATA_W-1:0] RESET_WORD = '0,
  parameter logic [DATA_W-1:0] KEEP_BITS  = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_keep,
  input  logic [DATA_W-1:0] wr_set,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_word
);
  localparam int SEL_W = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1;
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_NODES);

  logic [DATA_W-1:0]    store_q [NUM_NODES];
  logic [DATA_W-1:0]    store_d [NUM_NODES];
  logic [NUM_NODES-1:0] wr_hit;

  genvar g;
  generate
    for (g = 0; g < NUM_NODES; g++) begin : g_entry
      always_comb begin
        wr_hit[g]  = wr_en && (wr_idx == IDX_W'(g));
        store_d[g] = ((store_q[g] & wr_keep) | wr_set) & KEEP_BITS;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         store_q[g] <= RESET_WORD;
        else if (wr_hit[g]) store_q[g] <= store_d[g];
      end
    end
  endgenerate

  logic rd_hit;
  always_comb begin
    rd_hit  = ({1'b0, rd_idx} < LIMIT);
    rd_data = rd_hit ? store_q[rd_idx[SEL_W-1:0]] : '0;
    lk_hit  = ({1'b0, lk_idx} < LIMIT);
    lk_word = lk_hit ? store_q[lk_idx[SEL_W-1:0]] : '0;
  end
endmodule

// File: rtl/route_select.sv
module route_select
  import route_tbl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              hit,
  input  logic [DATA_W-1:0] word,
  input  pkt_class_e        cls,
  input  logic              bypass,
  input  logic [1:0]        dflt_link,
  output logic [MASK_W-1:0] mask,
  output logic              unroutable
);
  localparam int NIB = DATA_W / MASK_W;

  logic [DATA_W-1:0] sel_bits;
  logic [DATA_W-1:0] picked;
  logic [MASK_W-1:0] nib_or [NIB+1];

  always_comb begin
    sel_bits = (cls == CLS_RSVD) ? '0
             : (DATA_W'({MASK_W{1'b1}}) << (int'(cls) * FIELD_STRIDE));
    picked   = word & sel_bits;
  end

  assign nib_or[0] = '0;
  genvar n;
  generate
    for (n = 0; n < NIB; n++) begin : g_nib
      assign nib_or[n+1] = nib_or[n] | picked[n*MASK_W +: MASK_W];
    end
  endgenerate

  always_comb begin
    if (bypass) begin
      mask       = (dflt_link == 2'b11) ? MASK_W'(1) : (MASK_W'(2) << dflt_link);
      unroutable = 1'b0;
    end else if (!hit || cls == CLS_RSVD) begin
      mask       = '0;
      unroutable = 1'b1;
    end else begin
      mask       = nib_or[NIB];
      unroutable = 1'b0;
    end
  end
endmodule

// File: rtl/route_out_reg.sv
module route_out_reg #(
  parameter int MASK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MASK_W-1:0] in_mask,
  input  logic              in_unroutable,
  output logic              out_valid,
  output logic [MASK_W-1:0] out_mask,
  output logic              out_unroutable
);
  logic              valid_d, unr_d;
  logic [MASK_W-1:0] mask_d;

  always_comb begin
    valid_d = in_valid;
    mask_d  = in_valid ? in_mask : '0;
    unr_d   = in_valid & in_unroutable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_mask       <= '0;
      out_unroutable <= 1'b0;
    end else begin
      out_valid      <= valid_d;
      out_mask       <= mask_d;
      out_unroutable <= unr_d;
    end
  end
endmodule

// File: rtl/route_table_top.sv
module route_table_top
  import route_tbl_pkg::*;
#(
  parameter int NUM_NODES = 8,
  parameter int IDX_W     = 4,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [DATA_W-1:0] cfg_keep,
  input  logic [DATA_W-1:0] cfg_set,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              route_bypass,
  input  logic [1:0]        strap_dflt_link,
  input  logic              lkp_valid,
  input  logic [IDX_W-1:0]  lkp_dest,
  input  logic [1:0]        lkp_class,
  output logic              rte_valid,
  output logic [MASK_W-1:0] rte_mask,
  output logic              rte_unroutable
);
  localparam logic [DATA_W-1:0] FIELDS = DATA_W'(field_mask());
  localparam logic [DATA_W-1:0] INIT   = DATA_W'(local_only_word());

  logic              lk_hit;
  logic [DATA_W-1:0] lk_word;
  logic [MASK_W-1:0] sel_mask;
  logic              sel_unr;
  pkt_class_e        cls;

  assign cls = pkt_class_e'(lkp_class);

  route_entry_bank #(
    .NUM_NODES (NUM_NODES),
    .IDX_W     (IDX_W),
    .DATA_W    (DATA_W),
    .RESET_WORD(INIT),
    .KEEP_BITS (FIELDS)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_idx  (cfg_idx),
    .wr_keep (cfg_keep),
    .wr_set  (cfg_set),
    .rd_idx  (cfg_idx),
    .rd_data (cfg_rdata),
    .lk_idx  (lkp_dest),
    .lk_hit  (lk_hit),
    .lk_word (lk_word)
  );

  route_select #(.DATA_W(DATA_W)) u_sel (
    .hit        (lk_hit),
    .word       (lk_word),
    .cls        (cls),
    .bypass     (route_bypass),
    .dflt_link  (strap_dflt_link),
    .mask       (sel_mask),
    .unroutable (sel_unr)
  );

  route_out_reg #(.MASK_W(MASK_W)) u_out (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (lkp_valid),
    .in_mask        (sel_mask),
    .in_unroutable  (sel_unr),
    .out_valid      (rte_valid),
    .out_mask       (rte_mask),
    .out_unroutable (rte_unroutable)
  );
endmodule

// File: rtl/route_table_chk.sv
module route_table_chk #(
  parameter int NUM_NODES = 8,
  parameter int IDX_W     = 4,
  parameter int DATA_W    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [IDX_W-1:0]  cfg_idx,
  input logic [DATA_W-1:0] cfg_keep,
  input logic [DATA_W-1:0] cfg_set,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              route_bypass,
  input logic              lkp_valid,
  input logic [IDX_W-1:0]  lkp_dest,
  input logic [1:0]        lkp_class,
  input logic              rte_valid,
  input logic [3:0]        rte_mask,
  input logic              rte_unroutable
);
  localparam logic [DATA_W-1:0] FIELDS = DATA_W'(route_tbl_pkg::field_mask());
  localparam logic [IDX_W:0]    LIMIT  = (IDX_W+1)'(NUM_NODES);

  // R6: result valid one clock after the request
  assert_valid_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |=> rte_valid);
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |=> (!rte_valid && rte_mask == '0 && !rte_unroutable));

  // R7: out of range destination or reserved class without bypass
  assert_unroutable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && !route_bypass && (({1'b0, lkp_dest} >= LIMIT) || lkp_class == 2'b11))
    |=> (rte_unroutable && rte_mask == '0));

  // R8: bypass yields exactly one outlet and never unroutable
  assert_bypass_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && route_bypass) |=> ($countones(rte_mask) == 1 && !rte_unroutable));

  // R2: reserved bits never appear on readback
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~FIELDS) == '0);

  // R2: merge rule seen at the readback port
  assert_rmw_merge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && ({1'b0, cfg_idx} < LIMIT)) |=>
      ($stable(cfg_idx) -> cfg_rdata ==
        ((($past(cfg_rdata) & $past(cfg_keep)) | $past(cfg_set)) & FIELDS)));
endmodule

bind route_table_top route_table_chk #(
  .NUM_NODES(NUM_NODES), .IDX_W(IDX_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_idx(cfg_idx),
  .cfg_keep(cfg_keep), .cfg_set(cfg_set), .cfg_rdata(cfg_rdata),
  .route_bypass(route_bypass), .lkp_valid(lkp_valid), .lkp_dest(lkp_dest),
  .lkp_class(lkp_class), .rte_valid(rte_valid), .rte_mask(rte_mask),
  .rte_unroutable(rte_unroutable)
);

// File: tb/route_table_top_bench.sv
`timescale 1ns/1ps
module route_table_top_bench;
  localparam logic [31:0] FM   = 32'h000F0F0F;
  localparam logic [31:0] INIT = 32'h00010101;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [3:0]  cfg_idx;
  logic [31:0] cfg_keep, cfg_set, cfg_rdata;
  logic        route_bypass;
  logic [1:0]  strap_dflt_link;
  logic        lkp_valid;
  logic [3:0]  lkp_dest;
  logic [1:0]  lkp_class;
  logic        rte_valid;
  logic [3:0]  rte_mask;
  logic        rte_unroutable;

  always #4 clk = ~clk;

  route_table_top u_route_table_top (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_idx(cfg_idx),
    .cfg_keep(cfg_keep), .cfg_set(cfg_set), .cfg_rdata(cfg_rdata),
    .route_bypass(route_bypass), .strap_dflt_link(strap_dflt_link),
    .lkp_valid(lkp_valid), .lkp_dest(lkp_dest), .lkp_class(lkp_class),
    .rte_valid(rte_valid), .rte_mask(rte_mask), .rte_unroutable(rte_unroutable)
  );

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;
  logic [31:0] model [16];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected {unroutable, mask} from the requirements.
  function automatic logic [4:0] exp_route(input logic [31:0] w, input logic [3:0] d,
                                           input logic [1:0] c, input logic b,
                                           input logic [1:0] s);
    if (b) return {1'b0, (s == 2'b11) ? 4'b0001 : (4'b0010 << s)};   // R8
    if (d >= 4'd8 || c == 2'b11) return 5'b10000;                     // R7
    case (c)                                                          // R4
      2'b00:   return {1'b0, w[3:0]};
      2'b01:   return {1'b0, w[11:8]};
      default: return {1'b0, w[19:16]};
    endcase
  endfunction

  // One cycle: optional write, optional lookup; checks result and readback.
  task automatic step(input logic wr, input logic [3:0] widx, input logic [31:0] keep,
                      input logic [31:0] setv, input logic lk, input logic [3:0] dest,
                      input logic [1:0] cls, input logic byp, input logic [1:0] strap,
                      input string req);
    logic [4:0] e;
    e = exp_route(model[dest], dest, cls, byp, strap);   // old entry: R9
    cfg_wr_en = wr; cfg_idx = widx; cfg_keep = keep; cfg_set = setv;
    lkp_valid = lk; lkp_dest = dest; lkp_class = cls;
    route_bypass = byp; strap_dflt_link = strap;
    @(negedge clk);
    cfg_wr_en = 1'b0; lkp_valid = 1'b0;
    if (lk) begin
      chk({req, " valid R6"}, 32'(rte_valid), 32'd1);
      chk({req, " mask"}, 32'({rte_unroutable, rte_mask}), 32'(e));
    end else begin
      chk({req, " idle R6"}, 32'({rte_valid, rte_unroutable, rte_mask}), 32'd0);
    end
    if (wr && widx < 4'd8) model[widx] = ((model[widx] & keep) | setv) & FM;
    #1;
    chk({req, " readback R3"}, cfg_rdata, model[widx]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) model[i] = (i < 8) ? INIT : 32'd0;
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_idx = '0; cfg_keep = '0; cfg_set = '0;
    route_bypass = 1'b0; strap_dflt_link = 2'b00;
    lkp_valid = 1'b0; lkp_dest = '0; lkp_class = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset contents, R3 out-of-range readback
    chk("R6 reset valid", 32'(rte_valid), 32'd0);
    for (int i = 0; i < 16; i++) begin
      cfg_idx = 4'(i); #1;
      chk(i < 8 ? "R1 reset entry" : "R3 high index zero", cfg_rdata, model[i]);
    end

    // R4 default lookups per class
    step(0, 0, 0, 0, 1, 4'd2, 2'b00, 0, 0, "R4 req");
    step(0, 0, 0, 0, 1, 4'd7, 2'b01, 0, 0, "R4 rsp");
    step(0, 0, 0, 0, 1, 4'd0, 2'b10, 0, 0, "R4 bcast");
    // R7 unroutable
    step(0, 0, 0, 0, 1, 4'd9, 2'b00, 0, 0, "R7 high dest");
    step(0, 0, 0, 0, 1, 4'd3, 2'b11, 0, 0, "R7 rsvd class");
    // R8 bypass each strap
    for (int s = 0; s < 4; s++)
      step(0, 0, 0, 0, 1, 4'd13, 2'b11, 1, 2'(s), "R8 bypass");
    // R2 merge
    step(1, 4'd3, 32'h0, 32'hFFFFFFFF, 0, 0, 0, 0, 0, "R2 set all");
    step(1, 4'd3, 32'hFFFFFFF0, 32'h4, 1, 4'd3, 2'b00, 0, 0, "R2 keep R9");
    step(0, 0, 0, 0, 1, 4'd3, 2'b00, 0, 0, "R4 after write");
    // R5 multi-hot broadcast
    step(1, 4'd6, 32'hFFF0FFFF, 32'h000E0000, 0, 0, 0, 0, 0, "R5 write");
    step(0, 0, 0, 0, 1, 4'd6, 2'b10, 0, 0, "R5 bcast multi");
    // R9 same-cycle write and lookup
    step(1, 4'd5, 32'h0, 32'h00000808, 1, 4'd5, 2'b01, 0, 0, "R9 same cycle");
    step(0, 0, 0, 0, 1, 4'd5, 2'b01, 0, 0, "R9 after");
    // R2 write to index >= 8 ignored
    step(1, 4'd10, 32'h0, 32'hFFFFFFFF, 0, 0, 0, 0, 0, "R2 ignored");
    for (int i = 0; i < 8; i++) begin
      cfg_idx = 4'(i); #1;
      chk("R2 table unchanged", cfg_rdata, model[i]);
    end

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic wr, lk, byp;
      wr  = ($urandom_range(0, 2) == 0);
      lk  = ($urandom_range(0, 3) != 0);
      byp = ($urandom_range(0, 4) == 0);
      step(wr, 4'($urandom_range(0, 15)), $urandom, $urandom & $urandom,
           lk, 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)), byp,
           2'($urandom_range(0, 3)), "R4 random");
    end

    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule